// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns a predicate specification into per-element enable masks for a vector operation, one mask for the source operands and one for the destination (twin predication). A single shared mode bit chooses whether both masks come from integer registers or from condition-register fields. Two 3-bit selectors, one per side, then pick the register and the bit sense. The bits of each mask at and above the vector length are cleared. The integer selector code that is reserved raises an illegal-instruction flag.

The result is captured in registers when a one-cycle request strobe arrives. Each side also has a stepper. The stepper presents the index of the next enabled element, so an issue sequencer can walk the enabled elements one pulse at a time. It reports done when no enabled element is left.

Top module: `pmask_gen`

## Requirements
- R1: `pred_is_cr` picks the predicate source for both sides together: 0 means integer registers and 1 means condition-register fields. The two masks never come from different kinds of source.
- R2: In integer mode, selector 3'b000 enables every element below the effective vector length.
- R3: In integer mode, selector 3'b001 on either side sets `trap`. While `trap` is set, both masks are zero.
- R4: In integer mode, selectors 3'b010/3'b011 use `ireg3_val`, 3'b100/3'b101 use `ireg10_val` and 3'b110/3'b111 use `ireg30_val`. With an even code, element i is enabled when bit i is 1. With an odd code, element i is enabled when bit i is 0.
- R5: In condition mode, element i reads field 6+i of `cr_fields`. Field f occupies bits [4f+3:4f], with bit 3 = less-than, bit 2 = greater-than, bit 1 = equal and bit 0 = overflow/unordered. Selectors 3'b000/001 test less-than, 3'b010/011 greater-than, 3'b100/101 equal and 3'b110/111 overflow. An even code enables the element when the bit is 1 and an odd code when the bit is 0. Condition mode never sets `trap`.
- R6: All mask bits at positions at or above the effective vector length are 0. The effective length is `vl`, clamped to MAX_VL (64).
- R7: A field index 6+i at or beyond NUM_CRF (16) reads as an all-zero field. Such elements are therefore disabled by even codes and enabled by odd codes.
- R8: On a clock edge with `req_valid` high, masks and `trap` are captured and appear after that edge. Without `req_valid` they hold.
- R9: Synchronous active-high `rst` clears both masks and `trap`, sets both cursors to 0, and so raises both done flags.
- R10: Each stepper shows the lowest enabled mask index at or above its cursor on `*_idx`, with `*_done` low. The cursor returns to 0 on a capture. A `step` pulse moves the cursor one past the shown index. `*_done` is high when no enabled element remains.
- R11: When `trap` is set, both done flags are high from the first cycle after the capture.
- R12: A `step` while a side is done leaves that side unchanged. Source and destination step independently of each other's masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle capture strobe |
| pred_is_cr | input | 1 | Shared mode: 0 integer, 1 condition fields |
| src_sel | input | 3 | Source predicate selector |
| dst_sel | input | 3 | Destination predicate selector |
| ireg3_val | input | 64 | Read value of integer register 3 |
| ireg10_val | input | 64 | Read value of integer register 10 |
| ireg30_val | input | 64 | Read value of integer register 30 |
| cr_fields | input | 64 | Condition-register file, 16 fields of 4 bits |
| vl | input | 7 | Vector length (clamped to 64) |
| step | input | 1 | Advance both steppers past their current element |
| src_mask | output | 64 | Registered source enable mask |
| dst_mask | output | 64 | Registered destination enable mask |
| trap | output | 1 | Registered illegal-instruction flag |
| src_idx | output | 6 | Next enabled source element (0 when done) |
| src_done | output | 1 | No enabled source element remains |
| dst_idx | output | 6 | Next enabled destination element (0 when done) |
| dst_done | output | 1 | No enabled destination element remains |

## Verification
Masks and `trap` are due one edge after the `req_valid` edge. The steppers' index and done outputs are combinational from registered state, so they are valid in the same cycle as the new masks and again one edge after every `step`. The bench drives inputs on the falling edge and samples at the next falling edge, after exactly one rising edge has passed. It compares the outputs with masks and a cursor model computed in bench functions, and advances its cursor model only on a step that the model says is not done.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
    localparam int MAX_VL  = 64;
    localparam int NUM_CRF = 16;
    localparam int CR_BASE = 6;
    localparam int XLEN    = 64;
    localparam int VLW     = $clog2(MAX_VL + 1);
    localparam int IDXW    = $clog2(MAX_VL);

    typedef enum logic [1:0] {
        CB_LT = 2'd0,
        CB_GT = 2'd1,
        CB_EQ = 2'd2,
        CB_SO = 2'd3
    } cr_bit_e;

    typedef struct packed {
        logic [2:1] pick;
        logic       invert;
    } pred_sel_t;

    function automatic pred_sel_t split_sel(input logic [2:0] s);
        pred_sel_t r;
        r.pick   = s[2:1];
        r.invert = s[0];
        return r;
    endfunction

    // position inside a 4-bit field, less-than in the top bit
    function automatic int unsigned cr_bit_pos(input cr_bit_e b);
        return 3 - int'(b);
    endfunction

    function automatic logic [VLW-1:0] clamp_vl(input logic [VLW-1:0] v);
        return (v > VLW'(MAX_VL)) ? VLW'(MAX_VL) : v;
    endfunction
endpackage

// File: rtl/pmask_decode.sv
module pmask_decode
    import pmask_pkg::*;
#(
    parameter int N_EL  = MAX_VL,
    parameter int N_CRF = NUM_CRF,
    parameter int W     = XLEN
) (
    input  logic                   is_cr,
    input  logic [2:0]             sel,
    input  logic [W-1:0]           r3,
    input  logic [W-1:0]           r10,
    input  logic [W-1:0]           r30,
    input  logic [4*N_CRF-1:0]     crf,
    input  logic [VLW-1:0]         vl_eff,
    output logic [N_EL-1:0]        mask,
    output logic                   reserved
);
    pred_sel_t          ps;
    logic [N_EL-1:0]    cr_bits;
    logic [N_EL-1:0]    int_bits;
    logic [N_EL-1:0]    len_bits;
    logic [W-1:0]       reg_pick;
    cr_bit_e            which;

    assign ps    = split_sel(sel);
    assign which = cr_bit_e'(ps.pick);

    // per-element field fetch; fields past the file read as zero
    for (genvar i = 0; i < N_EL; i++) begin : g_el
        localparam int FI = CR_BASE + i;
        logic [3:0] fld;
        if (FI < N_CRF) begin : g_in
            assign fld = crf[4*FI +: 4];
        end else begin : g_out
            assign fld = 4'b0000;
        end
        assign cr_bits[i]  = fld[cr_bit_pos(which)] ^ ps.invert;
        assign len_bits[i] = (VLW'(i) < vl_eff);
    end

    always_comb begin
        unique case (ps.pick)
            2'b01:   reg_pick = r3;
            2'b10:   reg_pick = r10;
            2'b11:   reg_pick = r30;
            default: reg_pick = '0;
        endcase
    end

    always_comb begin
        if (ps.pick == 2'b00) begin
            int_bits = ps.invert ? '0 : '1;
        end else begin
            int_bits = reg_pick[N_EL-1:0] ^ {N_EL{ps.invert}};
        end
    end

    assign reserved = !is_cr && (sel == 3'b001);
    assign mask     = (is_cr ? cr_bits : int_bits) & len_bits;
endmodule

// File: rtl/pmask_stepper.sv
module pmask_stepper
    import pmask_pkg::*;
#(
    parameter int N_EL = MAX_VL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [N_EL-1:0]   mask_i,
    output logic [IDXW-1:0]   idx_o,
    output logic              done_o
);
    logic [VLW-1:0]   cur_q;
    logic [N_EL-1:0]  pending;

    always_comb begin
        for (int j = 0; j < N_EL; j++) begin
            pending[j] = mask_i[j] && (VLW'(j) >= cur_q);
        end
    end

    always_comb begin
        idx_o = '0;
        for (int j = N_EL - 1; j >= 0; j--) begin
            if (pending[j]) idx_o = IDXW'(j);
        end
    end

    assign done_o = (pending == '0);

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            cur_q <= '0;
        end else if (step_i && !done_o) begin
            cur_q <= VLW'(idx_o) + VLW'(1);
        end
    end

    assert_idx_enabled_R10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> mask_i[idx_o]);

    assert_step_advance_R10: assert property (@(posedge clk) disable iff (rst)
        (step_i && !done_o && !load_i) |=> (done_o || (idx_o > $past(idx_o))));

    assert_done_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/pmask_gen.sv
module pmask_gen
    import pmask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              pred_is_cr,
    input  logic [2:0]        src_sel,
    input  logic [2:0]        dst_sel,
    input  logic [XLEN-1:0]   ireg3_val,
    input  logic [XLEN-1:0]   ireg10_val,
    input  logic [XLEN-1:0]   ireg30_val,
    input  logic [4*NUM_CRF-1:0] cr_fields,
    input  logic [VLW-1:0]    vl,
    input  logic              step,
    output logic [MAX_VL-1:0] src_mask,
    output logic [MAX_VL-1:0] dst_mask,
    output logic              trap,
    output logic [IDXW-1:0]   src_idx,
    output logic              src_done,
    output logic [IDXW-1:0]   dst_idx,
    output logic              dst_done
);
    localparam int SIDES = 2;

    logic [VLW-1:0]    vl_eff;
    logic [2:0]        sel_a   [SIDES];
    logic [MAX_VL-1:0] mask_d  [SIDES];
    logic [MAX_VL-1:0] mask_q  [SIDES];
    logic [SIDES-1:0]  resv;
    logic [IDXW-1:0]   idx_a   [SIDES];
    logic [SIDES-1:0]  done_a;
    logic              trap_d;
    logic              trap_q;
    logic [VLW-1:0]    vl_q;

    assign vl_eff   = clamp_vl(vl);
    assign sel_a[0] = src_sel;
    assign sel_a[1] = dst_sel;
    assign trap_d   = |resv;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        pmask_decode #(.N_EL(MAX_VL), .N_CRF(NUM_CRF), .W(XLEN)) u_dec (
            .is_cr    (pred_is_cr),
            .sel      (sel_a[s]),
            .r3       (ireg3_val),
            .r10      (ireg10_val),
            .r30      (ireg30_val),
            .crf      (cr_fields),
            .vl_eff   (vl_eff),
            .mask     (mask_d[s]),
            .reserved (resv[s])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[s] <= '0;
            end else if (req_valid) begin
                mask_q[s] <= trap_d ? '0 : mask_d[s];
            end
        end

        pmask_stepper #(.N_EL(MAX_VL)) u_step (
            .clk    (clk),
            .rst    (rst),
            .load_i (req_valid),
            .step_i (step),
            .mask_i (mask_q[s]),
            .idx_o  (idx_a[s]),
            .done_o (done_a[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= 1'b0;
            vl_q   <= '0;
        end else if (req_valid) begin
            trap_q <= trap_d;
            vl_q   <= vl_eff;
        end
    end

    assign src_mask = mask_q[0];
    assign dst_mask = mask_q[1];
    assign trap     = trap_q;
    assign src_idx  = idx_a[0];
    assign dst_idx  = idx_a[1];
    assign src_done = done_a[0];
    assign dst_done = done_a[1];

    assert_trap_clears_R3: assert property (@(posedge clk) disable iff (rst)
        trap |-> (src_mask == '0 && dst_mask == '0));

    assert_trap_done_R11: assert property (@(posedge clk) disable iff (rst)
        trap |-> (src_done && dst_done));

    assert_vl_bound_R6: assert property (@(posedge clk) disable iff (rst)
        ((src_mask | dst_mask) >> vl_q) == '0);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(src_mask) && $stable(dst_mask) && $stable(trap)));

    assert_cr_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pred_is_cr) |=> !trap);
endmodule

// File: tb/tb_pmask_gen.sv
`timescale 1ns/1ps
module tb_pmask_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        pred_is_cr;
    logic [2:0]  src_sel, dst_sel;
    logic [63:0] r3, r10, r30, crf;
    logic [6:0]  vl;
    logic        step;
    logic [63:0] src_mask, dst_mask;
    logic        trap;
    logic [5:0]  src_idx, dst_idx;
    logic        src_done, dst_done;

    int checks = 0;
    int fails  = 0;
    int cur_s, cur_d;

    always #2.5 clk = ~clk;

    pmask_gen dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .pred_is_cr(pred_is_cr),
        .src_sel(src_sel), .dst_sel(dst_sel),
        .ireg3_val(r3), .ireg10_val(r10), .ireg30_val(r30),
        .cr_fields(crf), .vl(vl), .step(step),
        .src_mask(src_mask), .dst_mask(dst_mask), .trap(trap),
        .src_idx(src_idx), .src_done(src_done),
        .dst_idx(dst_idx), .dst_done(dst_done)
    );

    function automatic logic ref_trap(input logic cr, input logic [2:0] s, input logic [2:0] d);
        return !cr && (s == 3'b001 || d == 3'b001);
    endfunction

    function automatic logic [63:0] ref_mask(input logic cr, input logic [2:0] s,
            input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
            input logic [63:0] f, input logic [6:0] len);
        logic [63:0] m = '0;
        int n = (len > 7'd64) ? 64 : int'(len);
        for (int i = 0; i < 64; i++) begin
            logic bitv;
            if (i >= n) bitv = 1'b0;
            else if (!cr) begin
                case (s)
                    3'b000: bitv = 1'b1;
                    3'b001: bitv = 1'b0;
                    3'b010: bitv = a[i];
                    3'b011: bitv = !a[i];
                    3'b100: bitv = b[i];
                    3'b101: bitv = !b[i];
                    3'b110: bitv = c[i];
                    default: bitv = !c[i];
                endcase
            end else begin
                int fi = 6 + i;
                logic [3:0] nib = (fi < 16) ? f[4*fi +: 4] : 4'b0000;
                bitv = nib[3 - int'(s[2:1])] ^ s[0];
            end
            m[i] = bitv;
        end
        return m;
    endfunction

    function automatic int next_set(input logic [63:0] m, input int from);
        for (int j = from; j < 64; j++) if (m[j]) return j;
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_side(input string req, input string nm, input logic [63:0] m,
                              input int cur, input logic [5:0] idx, input logic dn);
        int e = next_set(m, cur);
        chk(req, {nm, " done"}, {63'd0, dn}, {63'd0, (e < 0)});
        if (e >= 0) chk(req, {nm, " idx"}, {58'd0, idx}, 64'(e));
    endtask

    // capture, check outputs, then walk up to nsteps with step pulses
    task automatic run_case(input string req, input logic cr, input logic [2:0] s, input logic [2:0] d,
                            input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                            input logic [63:0] f, input logic [6:0] len, input int nsteps);
        logic [63:0] es, ed;
        logic et;
        pred_is_cr = cr; src_sel = s; dst_sel = d;
        r3 = a; r10 = b; r30 = c; crf = f; vl = len;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        et = ref_trap(cr, s, d);
        es = et ? 64'd0 : ref_mask(cr, s, a, b, c, f, len);
        ed = et ? 64'd0 : ref_mask(cr, d, a, b, c, f, len);
        chk(req, "src_mask", src_mask, es);
        chk(req, "dst_mask", dst_mask, ed);
        chk(req, "trap", {63'd0, trap}, {63'd0, et});
        cur_s = 0; cur_d = 0;
        check_side("R10", "src", es, cur_s, src_idx, src_done);
        check_side("R10", "dst", ed, cur_d, dst_idx, dst_done);
        // scramble inputs: R8 registered outputs must hold
        r3 = ~r3; crf = ~crf; src_sel = ~src_sel;
        for (int k = 0; k < nsteps; k++) begin
            int ns = next_set(es, cur_s);
            int nd = next_set(ed, cur_d);
            step = 1'b1;
            @(negedge clk);
            step = 1'b0;
            if (ns >= 0) cur_s = ns + 1;
            if (nd >= 0) cur_d = nd + 1;
            check_side("R12", "src", es, cur_s, src_idx, src_done);
            check_side("R12", "dst", ed, cur_d, dst_idx, dst_done);
        end
        chk("R8", "src_mask hold", src_mask, es);
        chk("R8", "dst_mask hold", dst_mask, ed);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] pat;
        void'($urandom(32'd1234));
        rst = 1'b1; req_valid = 1'b0; step = 1'b0; pred_is_cr = 1'b0;
        src_sel = '0; dst_sel = '0; r3 = '0; r10 = '0; r30 = '0; crf = '0; vl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9", "src_mask", src_mask, 64'd0);
        chk("R9", "dst_mask", dst_mask, 64'd0);
        chk("R9", "trap", {63'd0, trap}, 64'd0);
        chk("R9", "done", {62'd0, src_done, dst_done}, 64'd3);

        pat = 64'hF0F0_1234_8000_0001;
        // R2 always-on, full, zero and clamped lengths
        run_case("R2", 1'b0, 3'b000, 3'b000, pat, pat, pat, pat, 7'd64, 3);
        run_case("R2", 1'b0, 3'b000, 3'b000, pat, pat, pat, pat, 7'd0, 1);
        run_case("R6", 1'b0, 3'b000, 3'b011, pat, pat, pat, pat, 7'd100, 2);
        run_case("R6", 1'b0, 3'b010, 3'b010, 64'hFFFF_FFFF_FFFF_FFFF, pat, pat, pat, 7'd5, 6);
        // R3 / R11 reserved code on either side
        run_case("R3", 1'b0, 3'b001, 3'b010, pat, pat, pat, pat, 7'd64, 2);
        run_case("R11", 1'b0, 3'b100, 3'b001, pat, pat, pat, pat, 7'd64, 2);
        // R4 register mapping and inversion
        run_case("R4", 1'b0, 3'b100, 3'b111, 64'h1, 64'h0000_0000_0000_00A5, 64'h0F, pat, 7'd12, 5);
        // R5 condition mode: code 001 does not trap
        run_case("R5", 1'b1, 3'b001, 3'b110, pat, pat, pat, 64'h8421_8421_5A5A_0000, 7'd64, 4);
        // R7 fields past the file with odd codes
        run_case("R7", 1'b1, 3'b101, 3'b100, pat, pat, pat, 64'hFFFF_FFFF_FFFF_FFFF, 7'd64, 12);
        // R1 random mix; the shared mode governs both sides
        for (int t = 0; t < 150; t++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            logic [63:0] c = {$urandom, $urandom};
            logic [63:0] f = {$urandom, $urandom};
            logic [6:0]  l = 7'($urandom_range(0, 80));
            run_case("R1", 1'($urandom), 3'($urandom), 3'($urandom), a, b, c, f, l,
                     int'($urandom_range(0, 8)));
        end
        // R9 synchronous reset clears captured state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "src_mask after rst", src_mask, 64'd0);
        chk("R9", "done after rst", {62'd0, src_done, dst_done}, 64'd3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule